// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer on a simple 32-bit register bus. The input clock first passes through an 8-bit prescaler and then through a power-of-two divider. The prescaler divides by its field value plus one. The divider divides by 16, 32, 64 or 128. Each divided tick lowers a 16-bit down-counter by one. When a tick arrives while the count is zero, the counter reloads from a reload register and the block flags an expiry. If the reset-enable bit is set, that expiry drives a system reset pulse of fixed length.

Software programs a timeout of N ticks by loading N-1 into the reload register while the timer is disabled. It then writes the counter and sets the enable bit. Writing the counter again restarts the countdown and realigns the division chain, which is how the watchdog is serviced. The reload register refuses writes while the timer is enabled. Clearing both enable bits stops the timer. To force an immediate reset, software clears the control word, writes 1 to the counter and then sets both enable bits.

The bus is a single-cycle valid/write strobe. Reads are combinational from the addressed register.

Top module: `wdt_top`

## Requirements
- R1: After reset, the control word reads 0x0000_0000, the reload register reads 0x0000_FFFF and the counter reads 0x0000_FFFF.
- R2: The control word sits at offset 0x0, the reload register at 0x4 and the counter at 0x8. All three read back through `bus_rdata`, zero-extended. The control fields are bit 0 enable, bit 1 reset-enable, bits 5:4 clock select and bits 15:8 prescaler. Every other control bit reads 0, and any other offset reads 0.
- R3: While enable is set, one divided tick occurs every (prescaler+1)·2^(4+select) input clocks, counted from the last counter write. Each tick lowers a non-zero count by exactly one.
- R4: A write to offset 0x8 replaces the count in the cycle after the strobe. It also clears the division chain, so the next tick comes one full tick period after that write.
- R5: A write to offset 0x4 updates the reload register only while enable is 0. While enable is 1 the write is ignored and the old value stays readable.
- R6: A tick arriving while the count is 0 loads the counter from the reload register and counts as an expiry.
- R7: An expiry with reset-enable set drives `sys_rst_o` high for exactly 4 input clocks, starting on the clock edge that performs the reload. An expiry with reset-enable clear leaves `sys_rst_o` low.
- R8: While enable is 0, the counter and the division chain hold their values. The only exception is a counter write.
- R9: With prescaler 0 and select 0, the sequence "control 0, counter 1, control 0x3" raises `sys_rst_o` on the 32nd clock edge after the edge that captured the final control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; drives the registers and the division chain |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| bus_valid | input | 1 | Bus access strobe for one cycle |
| bus_write | input | 1 | 1 = write access when `bus_valid` is high |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data of the addressed register |
| sys_rst_o | output | 1 | System reset pulse on expiry |

## Verification
- **Register writes:** a register write takes effect at the capturing edge. The bench therefore compares the readback 2 ns after each rising edge, when the new value is stable.
- **First tick:** for a counter write or an enabling control write captured at edge P, the first decrement is due at edge P+period. The directed checks wait exactly period-1 edges, check that the count is unchanged, then wait one more edge and check the decrement.
- **Reset pulse:** the reset pulse is registered on the reload edge and then lasts 4 edges. The bench checks the last low cycle, each high cycle and the first low cycle after the pulse.
- **Reference model:** a behavioural model counts enabled cycles since the last counter write. It predicts readback and `sys_rst_o` on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PRE_W = 8;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SEL_W-1:0] sel;
    logic             rst_en;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_q,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              cnt_wr,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_RLD  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(8);

  ctrl_t            ctrl_d;
  logic [CNT_W-1:0] reload_d;
  logic             wr;
  logic             unused_wdata;

  assign unused_wdata = ^{bus_wdata[DATA_W-1:16], bus_wdata[7:6], bus_wdata[3:2]};
  assign wr     = bus_valid && bus_write;
  assign cnt_wr = wr && (bus_addr == OFS_CNT);

  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    if (wr && (bus_addr == OFS_CTRL)) begin
      ctrl_d.en     = bus_wdata[0];
      ctrl_d.rst_en = bus_wdata[1];
      ctrl_d.sel    = bus_wdata[5:4];
      ctrl_d.pre    = bus_wdata[15:8];
    end
    if (wr && (bus_addr == OFS_RLD) && !ctrl_q.en)
      reload_d = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '1;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CTRL) begin
      bus_rdata[0]    = ctrl_q.en;
      bus_rdata[1]    = ctrl_q.rst_en;
      bus_rdata[5:4]  = ctrl_q.sel;
      bus_rdata[15:8] = ctrl_q.pre;
    end else if (bus_addr == OFS_RLD) begin
      bus_rdata[CNT_W-1:0] = reload_q;
    end else if (bus_addr == OFS_CNT) begin
      bus_rdata[CNT_W-1:0] = cnt_q;
    end
  end
endmodule

// File: rtl/wdt_clkdiv.sv
module wdt_clkdiv
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [PRE_W-1:0] pre,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = 4 + (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pc_q, pc_d;
  logic [DIV_W-1:0] dc_q, dc_d;
  logic [DIV_W-1:0] mask;
  logic             pre_tick;

  always_comb begin
    for (int i = 0; i < DIV_W; i++)
      mask[i] = (i < 4 + int'(sel));
  end

  assign pre_tick = en && (pc_q >= pre);
  assign tick     = pre_tick && ((dc_q & mask) == mask);

  always_comb begin
    pc_d = pc_q;
    dc_d = dc_q;
    if (clr) begin
      pc_d = '0;
      dc_d = '0;
    end else if (en) begin
      pc_d = pre_tick ? '0 : pc_q + 1'b1;
      if (pre_tick) dc_d = dc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      dc_q <= '0;
    end else begin
      pc_q <= pc_d;
      dc_q <= dc_d;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_d  = reload;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_rstgen.sv
module wdt_rstgen #(
  parameter int RST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic rst_out
);
  localparam int RW = $clog2(RST_LEN + 1);

  logic [RW-1:0] rc_q, rc_d;

  always_comb begin
    if (fire)              rc_d = RW'(RST_LEN);
    else if (rc_q != '0)   rc_d = rc_q - 1'b1;
    else                   rc_d = rc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rc_q <= '0;
    else        rc_q <= rc_d;
  end

  assign rst_out = (rc_q != '0);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  ctrl_t            ctrl_q;
  logic             ctrl_en;
  logic             ctrl_rsten;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_wr;
  logic             tick;
  logic             expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign ctrl_en    = ctrl_q.en;
  assign ctrl_rsten = ctrl_q.rst_en;

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_q     (cnt_q),
    .ctrl_q    (ctrl_q),
    .reload_q  (reload_q),
    .cnt_wr    (cnt_wr),
    .bus_rdata (bus_rdata)
  );

  wdt_clkdiv div_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (ctrl_en),
    .clr   (cnt_wr),
    .pre   (ctrl_q.pre),
    .sel   (ctrl_q.sel),
    .tick  (tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (cnt_wr),
    .load_val (bus_wdata[CNT_W-1:0]),
    .tick     (tick),
    .reload   (reload_q),
    .cnt_q    (cnt_q),
    .expire   (expire)
  );

  wdt_rstgen #(.RST_LEN(RST_LEN)) rgen_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fire    (expire && ctrl_rsten),
    .rst_out (sys_rst_o)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              en,
  input logic              rst_en,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload,
  input logic              sys_rst
);
  logic [7:0] hi_q;
  logic       cwr;
  logic       rwr;

  assign cwr = bus_valid && bus_write && (bus_addr == ADDR_W'(8));
  assign rwr = bus_valid && bus_write && (bus_addr == ADDR_W'(4));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_q <= '0;
    else if (sys_rst) hi_q <= hi_q + 1'b1;
    else              hi_q <= '0;
  end

  // R7
  rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> (hi_q < 8'(RST_LEN)));

  // R7
  rst_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (hi_q == 8'(RST_LEN)));

  // R7
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(en && rst_en));

  // R5
  reload_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rwr && en) |=> $stable(reload));

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cwr |=> (cnt == $past(bus_wdata[CNT_W-1:0])));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cwr) |=> $stable(cnt));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cwr) |=> ((cnt == $past(cnt)) ||
                      (cnt == CNT_W'($past(cnt) - 1'b1)) ||
                      (($past(cnt) == '0) && (cnt == $past(reload)))));
endmodule

bind wdt_top wdt_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RST_LEN(RST_LEN)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .en        (ctrl_en),
  .rst_en    (ctrl_rsten),
  .cnt       (cnt_q),
  .reload    (reload_q),
  .sys_rst   (sys_rst_o)
);

// File: tb/wdt_top_tb_top.sv
`timescale 1ns/1ps
module wdt_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        sys_rst_o;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;
  bit done   = 0;

  // behavioural reference state
  int unsigned m_ctrl, m_reload, m_cnt, m_el, m_rl;

  wdt_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sys_rst_o (sys_rst_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, one step per clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_reload = 32'hFFFF; m_cnt = 32'hFFFF; m_el = 0; m_rl = 0;
    end else begin
      int unsigned period, oc, orl;
      bit en, rsen, tk, fire;
      oc = m_ctrl; orl = m_reload;
      en = oc[0]; rsen = oc[1];
      period = (((oc >> 8) & 32'hFF) + 1) << (4 + ((oc >> 4) & 3));
      tk = en && (((m_el + 1) % period) == 0);
      fire = 0;
      if (bus_valid && bus_write && bus_addr == 4'h0) m_ctrl = bus_wdata & 32'h0000_FF33;
      if (bus_valid && bus_write && bus_addr == 4'h4 && !en) m_reload = bus_wdata & 32'hFFFF;
      if (bus_valid && bus_write && bus_addr == 4'h8) begin
        m_cnt = bus_wdata & 32'hFFFF; m_el = 0;
      end else begin
        if (en) m_el++;
        if (tk) begin
          if (m_cnt == 0) begin m_cnt = orl; fire = rsen; end
          else m_cnt--;
        end
      end
      if (fire) m_rl = 4;
      else if (m_rl > 0) m_rl--;
    end
  end

  always @(posedge clk) begin
    #2;
    if (cmp_on && !done) begin
      int unsigned exp_rd;
      case (bus_addr)
        4'h0: exp_rd = m_ctrl;
        4'h4: exp_rd = m_reload;
        4'h8: exp_rd = m_cnt;
        default: exp_rd = 0;
      endcase
      check(sys_rst_o === (m_rl > 0), "R7 model sys_rst", int'(sys_rst_o), int'(m_rl > 0));
      check(bus_rdata === exp_rd, "R3 model readback", int'(bus_rdata), int'(exp_rd));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] next_a);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_addr = next_a; bus_wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    int n;
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    // R1 reset values
    rd(4'h0, v); check(v == 32'h0, "R1 ctrl reset", v, 0);
    rd(4'h4, v); check(v == 32'hFFFF, "R1 reload reset", v, 32'hFFFF);
    rd(4'h8, v); check(v == 32'hFFFF, "R1 counter reset", v, 32'hFFFF);

    // R2 field mask and unmapped offset
    wr(4'h0, 32'hFFFF_FFFC, 4'h0);
    rd(4'h0, v); check(v == 32'h0000_FF30, "R2 ctrl readback mask", v, 32'h0000_FF30);
    rd(4'hC, v); check(v == 32'h0, "R2 unmapped read", v, 0);

    // R5 reload accepted while disabled
    wr(4'h4, 32'h0000_0123, 4'h4);
    rd(4'h4, v); check(v == 32'h123, "R5 reload write when disabled", v, 32'h123);

    // R3/R4 prescaler 1, select 0: period 32
    wr(4'h0, 32'h0000_0100, 4'h0);
    wr(4'h8, 32'h0000_0005, 4'h8);
    rd(4'h8, v); check(v == 5, "R4 counter write", v, 5);
    wr(4'h0, 32'h0000_0101, 4'h8);
    edges(31); check(bus_rdata == 5, "R3 no tick before period", bus_rdata, 5);
    edges(1);  check(bus_rdata == 4, "R3 tick at period 32", bus_rdata, 4);
    edges(32); check(bus_rdata == 3, "R3 second tick", bus_rdata, 3);

    // R5 reload write ignored while enabled
    wr(4'h4, 32'h0000_4567, 4'h4);
    #1; check(bus_rdata == 32'h123, "R5 reload locked when enabled", bus_rdata, 32'h123);

    // R8 freeze when disabled
    wr(4'h0, 32'h0000_0100, 4'h8);
    rd(4'h8, v);
    edges(100);
    rd(4'h8, v2); check(v2 == v, "R8 counter frozen", v2, v);

    // R6/R7 expiry with reset enable, period 16
    wr(4'h4, 32'h0000_0002, 4'h4);
    wr(4'h0, 32'h0000_0002, 4'h0);
    wr(4'h8, 32'h0000_0000, 4'h8);
    wr(4'h0, 32'h0000_0003, 4'h8);
    edges(15); check(sys_rst_o == 0, "R7 no reset before expiry", sys_rst_o, 0);
    check(bus_rdata == 0, "R6 count zero before expiry", bus_rdata, 0);
    edges(1);  check(sys_rst_o == 1, "R7 reset at expiry", sys_rst_o, 1);
    check(bus_rdata == 2, "R6 reload on expiry", bus_rdata, 2);
    for (int i = 0; i < 3; i++) begin
      edges(1); check(sys_rst_o == 1, "R7 reset held", sys_rst_o, 1);
    end
    edges(1); check(sys_rst_o == 0, "R7 reset ends after 4", sys_rst_o, 0);

    // R6/R7 expiry without reset enable
    wr(4'h0, 32'h0000_0000, 4'h0);
    wr(4'h8, 32'h0000_0000, 4'h8);
    wr(4'h0, 32'h0000_0001, 4'h8);
    edges(16); check(bus_rdata == 2, "R6 reload without reset enable", bus_rdata, 2);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      edges(1); if (sys_rst_o) n++;
    end
    check(n == 0, "R7 no pulse with reset-enable clear", n, 0);

    // R9 forced reset sequence
    wr(4'h0, 32'h0000_0000, 4'h0);
    wr(4'h8, 32'h0000_0001, 4'h0);
    wr(4'h0, 32'h0000_0003, 4'h8);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      edges(1); n++;
      if (sys_rst_o) break;
    end
    check(n == 32, "R9 forced reset latency", n, 32);
    n = 1;
    for (int i = 0; i < 10; i++) begin
      edges(1); if (sys_rst_o) n++; else break;
    end
    check(n == 4, "R7 forced pulse width", n, 4);

    // R4 counter write restarts division chain
    wr(4'h0, 32'h0000_0000, 4'h0);
    wr(4'h8, 32'h0000_000A, 4'h0);
    wr(4'h0, 32'h0000_0001, 4'h8);
    edges(10);
    wr(4'h8, 32'h0000_000A, 4'h8);
    edges(15); check(bus_rdata == 10, "R4 restart delays tick", bus_rdata, 10);
    edges(1);  check(bus_rdata == 9, "R4 tick one period after write", bus_rdata, 9);

    edges(5);
    finish_run();
  end
endmodule